// File: doc/BRIEF.md
# Sensor Conditioner Status Controller

This block holds the one-byte general status word of a sensor signal-conditioning device and drives its end-of-conversion pin. Commands arrive on a valid/ready handshake. Each command is tagged as a measurement or a non-measurement. The arithmetic unit, the checksum engine and the bus front end live elsewhere. Their outcomes reach this block as single-cycle strobes: a calculation-done pulse, a saturation pulse, and a checksum-valid pulse that carries a pass/fail flag.

Back-pressure works as follows. `cmd_ready` is low whenever the block is busy. A command is taken only in a cycle where `cmd_valid` and `cmd_ready` are both high. A command offered while `cmd_ready` is low is dropped rather than held, so the producer must keep `cmd_valid` asserted until it sees a transfer. A cyclic run is started by a plain strobe. Once started, it keeps the block busy until a stop strobe arrives. Mode and configuration-set writes are plain strobes that take effect only while the block is idle.

A single active-low reset covers both power-on reset and the external reset pin. The first checksum result after that reset is the only one the memory-error bit ever records.

Top module: `sc_status_ctrl`

## Requirements
- R1: `status` is packed as: bit 7 always 0, bit 6 powered, bit 5 busy, bits [4:3] mode, bit 2 memory error, bit 1 configuration set, bit 0 ALU saturation.
- R2: Bit 6 is 0 while `rst_n` is low and reads 1 from the first rising clock edge after reset is released.
- R3: `cmd_ready` equals the inverse of `busy`, and `busy` is also status bit 5. An accepted command raises `busy` at the next edge. `calc_done` ends a pending command at the next edge. A command offered while busy is ignored and does not change `eoc` or bit 0.
- R4: `cyc_start` is accepted when the block is idle and `cmd_valid` is low. From the following edge, `busy` stays 1 without a gap until `cyc_stop`. During the run, every `calc_done` counts as a completed measurement.
- R5: The mode field resets to 00 (Normal) and takes `mode_val` on `mode_wr` while idle, for code 00 or 01 (Command) only. Reserved codes 10 and 11, and any write made while busy, leave the field unchanged.
- R6: Bit 2 resets to 0. The first `mem_chk_valid` after reset loads it with `mem_chk_fail` (1 = failure). Later checksum pulses are ignored until the next reset.
- R7: Bit 1 resets to 0 (first configuration set). `cfg_wr` while idle loads `cfg_val` (1 = second set). A write while busy is ignored.
- R8: When a measurement completes, bit 0 becomes 1 if `alu_sat` was high in any cycle of that measurement, including the cycle of `calc_done`. Otherwise it becomes 0. An accepted command or cyclic start clears bit 0. `alu_sat` outside a measurement is ignored.
- R9: `eoc` rises at the edge of a measurement's `calc_done` when `int_setup` is 00. With any other setup it is left unchanged. It returns low at the edge that accepts the next command or cyclic start.
- R10: While reset is asserted, `status` is 0x00 and `busy` and `eoc` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low power-on / pin reset |
| cmd_valid | input | 1 | Command offered |
| cmd_ready | output | 1 | Command can be accepted (not busy) |
| cmd_is_meas | input | 1 | Offered command is a measurement |
| cyc_start | input | 1 | Start cyclic measurement |
| cyc_stop | input | 1 | Stop cyclic measurement |
| mode_wr | input | 1 | Mode write strobe |
| mode_val | input | 2 | Mode code to write |
| cfg_wr | input | 1 | Configuration-set write strobe |
| cfg_val | input | 1 | Configuration set to select |
| alu_sat | input | 1 | Saturation pulse from the arithmetic unit |
| calc_done | input | 1 | Result of current operation available |
| int_setup | input | INT_W | Interrupt-threshold setup; 0 enables end-of-conversion |
| mem_chk_valid | input | 1 | Checksum result strobe |
| mem_chk_fail | input | 1 | Checksum failed |
| status | output | 8 | General status byte |
| busy | output | 1 | Busy flag |
| eoc | output | 1 | End-of-conversion pin |

## Verification
Two functions can land in the same cycle: the saturation pulse and the completion strobe can both arrive in a measurement's final cycle, and a new command can be offered in that same completion cycle. The bench provokes both cases directly. The expected outcome is that bit 0 reads 1 and that the command is dropped, because `busy` is still high in that cycle. A cyclic stop that coincides with a completion is also driven; the result must still be published. A long pseudo-random phase then piles these strobes on top of each other, and a behavioural model checks every status field, `busy` and `eoc` each cycle.

// File: rtl/sc_status_pkg.sv
package sc_status_pkg;
  localparam int MODE_W = 2;
  localparam logic [MODE_W-1:0] MODE_NORMAL  = 2'b00;
  localparam logic [MODE_W-1:0] MODE_COMMAND = 2'b01;

  typedef struct packed {
    logic              zero;
    logic              powered;
    logic              busy;
    logic [MODE_W-1:0] mode;
    logic              mem_err;
    logic              cfg_set;
    logic              alu_sat;
  } sc_status_t;

  function automatic logic mode_legal(input logic [MODE_W-1:0] m);
    return (m == MODE_NORMAL) || (m == MODE_COMMAND);
  endfunction
endpackage

// File: rtl/sc_pwrup_capture.sv
module sc_pwrup_capture (
  input  logic clk,
  input  logic rst_n,
  input  logic chk_valid,
  input  logic chk_fail,
  output logic powered,
  output logic mem_err
);
  logic locked_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      powered  <= 1'b0;
      mem_err  <= 1'b0;
      locked_q <= 1'b0;
    end else begin
      powered <= 1'b1;
      if (chk_valid && !locked_q) begin
        mem_err  <= chk_fail;
        locked_q <= 1'b1;
      end
    end
  end

  AST_MEMERR_LOCKED: assert property (@(posedge clk) disable iff (!rst_n)
    locked_q |=> $stable(mem_err)); // R6
  AST_POWERED_STAYS: assert property (@(posedge clk) disable iff (!rst_n)
    powered |=> powered); // R2
endmodule

// File: rtl/sc_busy_tracker.sv
module sc_busy_tracker (
  input  logic clk,
  input  logic rst_n,
  input  logic cmd_valid,
  input  logic cmd_is_meas,
  input  logic cyc_start,
  input  logic cyc_stop,
  input  logic calc_done,
  output logic busy,
  output logic accept,
  output logic meas_active,
  output logic meas_done,
  output logic cyc_on
);
  logic pend_q, pend_meas_q, cyc_q;
  logic cmd_take, cyc_take;

  assign busy        = pend_q | cyc_q;
  assign cyc_on      = cyc_q;
  assign cmd_take    = cmd_valid & ~busy;
  assign cyc_take    = cyc_start & ~busy & ~cmd_valid;
  assign accept      = cmd_take | cyc_take;
  assign meas_active = (pend_q & pend_meas_q) | cyc_q;
  assign meas_done   = calc_done & meas_active;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pend_q      <= 1'b0;
      pend_meas_q <= 1'b0;
      cyc_q       <= 1'b0;
    end else begin
      if (cmd_take) begin
        pend_q      <= 1'b1;
        pend_meas_q <= cmd_is_meas;
      end else if (calc_done && pend_q) begin
        pend_q      <= 1'b0;
        pend_meas_q <= 1'b0;
      end
      if (cyc_take)              cyc_q <= 1'b1;
      else if (cyc_stop && cyc_q) cyc_q <= 1'b0;
    end
  end

  AST_PEND_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !cyc_q && !calc_done) |=> busy); // R3
  AST_CYCLIC_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    (cyc_q && !cyc_stop) |=> (busy && cyc_q)); // R4
  AST_ACCEPT_SETS_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    accept |=> busy); // R3
endmodule

// File: rtl/sc_result_flags.sv
module sc_result_flags #(
  parameter int INT_W = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             accept,
  input  logic             meas_active,
  input  logic             meas_done,
  input  logic             alu_sat,
  input  logic [INT_W-1:0] int_setup,
  output logic             sat_bit,
  output logic             eoc
);
  logic sat_seen_q;
  logic eoc_enabled;

  assign eoc_enabled = (int_setup == '0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sat_seen_q <= 1'b0;
      sat_bit    <= 1'b0;
      eoc        <= 1'b0;
    end else begin
      if (accept) begin
        sat_seen_q <= 1'b0;
        sat_bit    <= 1'b0;
        eoc        <= 1'b0;
      end else if (meas_done) begin
        sat_bit    <= sat_seen_q | alu_sat;
        sat_seen_q <= 1'b0;
        if (eoc_enabled) eoc <= 1'b1;
      end else if (meas_active && alu_sat) begin
        sat_seen_q <= 1'b1;
      end
    end
  end

  AST_EOC_AFTER_MEAS: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(eoc) |-> $past(meas_done)); // R9
  AST_ACCEPT_CLEARS_SAT: assert property (@(posedge clk) disable iff (!rst_n)
    accept |=> (!sat_bit && !eoc)); // R8
  AST_SAT_ONLY_AT_DONE: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sat_bit) |-> $past(meas_done)); // R8
endmodule

// File: rtl/sc_status_ctrl.sv
module sc_status_ctrl
  import sc_status_pkg::*;
#(
  parameter int INT_W = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cmd_valid,
  output logic             cmd_ready,
  input  logic             cmd_is_meas,
  input  logic             cyc_start,
  input  logic             cyc_stop,
  input  logic             mode_wr,
  input  logic [1:0]       mode_val,
  input  logic             cfg_wr,
  input  logic             cfg_val,
  input  logic             alu_sat,
  input  logic             calc_done,
  input  logic [INT_W-1:0] int_setup,
  input  logic             mem_chk_valid,
  input  logic             mem_chk_fail,
  output logic [7:0]       status,
  output logic             busy,
  output logic             eoc
);
  logic              powered, mem_err;
  logic              accept, meas_active, meas_done, cyc_on;
  logic              sat_bit;
  logic [MODE_W-1:0] mode_q;
  logic              cfg_q;
  sc_status_t        st;

  sc_pwrup_capture u_pwr (
    .clk(clk), .rst_n(rst_n),
    .chk_valid(mem_chk_valid), .chk_fail(mem_chk_fail),
    .powered(powered), .mem_err(mem_err)
  );

  sc_busy_tracker u_busy (
    .clk(clk), .rst_n(rst_n),
    .cmd_valid(cmd_valid), .cmd_is_meas(cmd_is_meas),
    .cyc_start(cyc_start), .cyc_stop(cyc_stop), .calc_done(calc_done),
    .busy(busy), .accept(accept), .meas_active(meas_active),
    .meas_done(meas_done), .cyc_on(cyc_on)
  );

  sc_result_flags #(.INT_W(INT_W)) u_res (
    .clk(clk), .rst_n(rst_n),
    .accept(accept), .meas_active(meas_active), .meas_done(meas_done),
    .alu_sat(alu_sat), .int_setup(int_setup),
    .sat_bit(sat_bit), .eoc(eoc)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode_q <= MODE_NORMAL;
      cfg_q  <= 1'b0;
    end else if (!busy) begin
      if (mode_wr && mode_legal(mode_val)) mode_q <= mode_val;
      if (cfg_wr) cfg_q <= cfg_val;
    end
  end

  always_comb begin
    st         = '0;
    st.zero    = 1'b0;
    st.powered = powered;
    st.busy    = busy;
    st.mode    = mode_q;
    st.mem_err = mem_err;
    st.cfg_set = cfg_q;
    st.alu_sat = sat_bit;
  end

  assign status    = st;
  assign cmd_ready = ~busy;

  AST_MODE_LEGAL: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_q != 2'b10) && (mode_q != 2'b11)); // R5
  AST_CFG_FROZEN_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    busy |=> $stable(cfg_q)); // R7
  AST_MODE_FROZEN_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    busy |=> $stable(mode_q)); // R5
  AST_CYC_IMPLIES_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    cyc_on |-> (status[5] && !cmd_ready)); // R4
endmodule

// File: tb/tb_sc_status_ctrl.sv
module tb_sc_status_ctrl;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic cmd_valid = 0, cmd_is_meas = 0, cyc_start = 0, cyc_stop = 0;
  logic mode_wr = 0, cfg_wr = 0, cfg_val = 0, alu_sat = 0, calc_done = 0;
  logic mem_chk_valid = 0, mem_chk_fail = 0;
  logic [1:0] mode_val = 0;
  logic [1:0] int_setup = 0;
  logic cmd_ready, busy, eoc;
  logic [7:0] status;

  always #2.5 clk = ~clk;

  sc_status_ctrl #(.INT_W(2)) dut (
    .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_ready(cmd_ready),
    .cmd_is_meas(cmd_is_meas), .cyc_start(cyc_start), .cyc_stop(cyc_stop),
    .mode_wr(mode_wr), .mode_val(mode_val), .cfg_wr(cfg_wr), .cfg_val(cfg_val),
    .alu_sat(alu_sat), .calc_done(calc_done), .int_setup(int_setup),
    .mem_chk_valid(mem_chk_valid), .mem_chk_fail(mem_chk_fail),
    .status(status), .busy(busy), .eoc(eoc)
  );

  int checks = 0, fails = 0;
  bit finished = 0;

  task automatic chk(input string req, input string what, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s %s: actual %0d expected %0d at %0t", req, what, act, exp, $time);
    end
  endtask

  // behavioural reference model
  bit m_pwr, m_pend, m_pmeas, m_cyc, m_cfg, m_mem, m_lock, m_seen, m_sat, m_eoc;
  int m_mode;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_pwr = 0; m_pend = 0; m_pmeas = 0; m_cyc = 0; m_cfg = 0;
      m_mem = 0; m_lock = 0; m_seen = 0; m_sat = 0; m_eoc = 0; m_mode = 0;
    end else begin
      bit was_busy, took_cmd, took_cyc, in_meas, done_meas;
      was_busy  = m_pend || m_cyc;
      took_cmd  = cmd_valid && !was_busy;
      took_cyc  = cyc_start && !was_busy && !cmd_valid;
      in_meas   = (m_pend && m_pmeas) || m_cyc;
      done_meas = calc_done && in_meas;
      m_pwr = 1;
      if (!m_lock && mem_chk_valid) begin m_mem = mem_chk_fail; m_lock = 1; end
      if (!was_busy && mode_wr && mode_val < 2) m_mode = mode_val;
      if (!was_busy && cfg_wr) m_cfg = cfg_val;
      if (took_cmd || took_cyc) begin
        m_sat = 0; m_seen = 0; m_eoc = 0;
      end else if (done_meas) begin
        m_sat = m_seen || alu_sat; m_seen = 0;
        if (int_setup == 0) m_eoc = 1;
      end else if (in_meas && alu_sat) m_seen = 1;
      if (took_cmd) begin m_pend = 1; m_pmeas = cmd_is_meas; end
      else if (calc_done && m_pend) begin m_pend = 0; m_pmeas = 0; end
      if (took_cyc) m_cyc = 1;
      else if (cyc_stop && m_cyc) m_cyc = 0;
    end
  end

  always @(negedge clk) if (!finished) begin
    bit mb;
    mb = m_pend || m_cyc;
    chk("R1", "bit7", status[7], 0);
    chk("R2", "powered", status[6], m_pwr);
    chk(m_cyc ? "R4" : "R3", "busy bit", status[5], mb);
    chk("R3", "busy pin", busy, mb);
    chk("R3", "cmd_ready", cmd_ready, !mb);
    chk("R5", "mode", status[4:3], m_mode);
    chk("R6", "mem_err", status[2], m_mem);
    chk("R7", "cfg", status[1], m_cfg);
    chk("R8", "sat", status[0], m_sat);
    chk("R9", "eoc", eoc, m_eoc);
  end

  task automatic tick(); @(negedge clk); #1; endtask
  task automatic clr();
    cmd_valid = 0; cmd_is_meas = 0; cyc_start = 0; cyc_stop = 0; mode_wr = 0;
    cfg_wr = 0; alu_sat = 0; calc_done = 0; mem_chk_valid = 0; mem_chk_fail = 0;
  endtask

  task automatic summary();
    if (!finished) begin
      finished = 1;
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    checks++; fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    summary();
  end

  initial begin
    logic [15:0] lf;
    clr(); rst_n = 0;
    tick(); tick();
    chk("R10", "reset status", status, 0);
    chk("R10", "reset eoc", eoc, 0);
    chk("R10", "reset busy", busy, 0);
    rst_n = 1; tick();
    chk("R2", "powered after release", status[6], 1);
    // R6: first checksum pass captured, later fail ignored
    mem_chk_valid = 1; mem_chk_fail = 0; tick(); clr();
    mem_chk_valid = 1; mem_chk_fail = 1; tick(); clr(); tick();
    chk("R6", "late checksum ignored", status[2], 0);
    // R3: non-measurement command
    cmd_valid = 1; tick(); clr(); tick(); tick();
    calc_done = 1; tick(); clr(); tick();
    chk("R9", "no eoc after non-meas", eoc, 0);
    // R8: measurement with early saturation, command offered while busy
    cmd_valid = 1; cmd_is_meas = 1; tick(); clr();
    alu_sat = 1; tick(); clr();
    cmd_valid = 1; tick(); clr();
    calc_done = 1; tick(); clr(); tick();
    chk("R8", "sticky sat", status[0], 1);
    chk("R9", "eoc set", eoc, 1);
    // same-cycle sat + done, command offered in done cycle
    cmd_valid = 1; cmd_is_meas = 1; tick(); clr(); tick();
    calc_done = 1; alu_sat = 1; cmd_valid = 1; tick(); clr(); tick();
    chk("R8", "sat in done cycle", status[0], 1);
    chk("R3", "command in done cycle dropped", busy, 0);
    // clean measurement
    cmd_valid = 1; cmd_is_meas = 1; tick(); clr();
    calc_done = 1; tick(); clr(); tick();
    chk("R8", "clean result", status[0], 0);
    // R5, R7 writes while idle, including reserved codes
    mode_wr = 1; mode_val = 1; tick(); mode_val = 2; tick(); mode_val = 3; tick(); clr();
    cfg_wr = 1; cfg_val = 1; tick(); clr(); tick();
    chk("R5", "reserved ignored", status[4:3], 1);
    chk("R7", "second set", status[1], 1);
    // writes while busy ignored
    cmd_valid = 1; tick(); clr();
    mode_wr = 1; mode_val = 0; cfg_wr = 1; cfg_val = 0; tick(); clr();
    calc_done = 1; tick(); clr(); tick();
    chk("R7", "busy write ignored", status[1], 1);
    // R4 cyclic run
    cyc_start = 1; tick(); clr();
    for (int i = 0; i < 4; i++) begin
      tick(); calc_done = 1; alu_sat = i[0]; tick(); clr();
    end
    cmd_valid = 1; tick(); clr();
    chk("R4", "busy during cyclic", busy, 1);
    cyc_stop = 1; calc_done = 1; tick(); clr(); tick();
    chk("R4", "stopped", busy, 0);
    // R9 with nonzero interrupt setup
    int_setup = 1;
    cmd_valid = 1; cmd_is_meas = 1; tick(); clr();
    calc_done = 1; tick(); clr(); tick();
    chk("R9", "eoc held low", eoc, 0);
    int_setup = 0;
    // pin reset then failing checksum
    rst_n = 0; tick(); tick(); rst_n = 1; tick();
    mem_chk_valid = 1; mem_chk_fail = 1; tick(); clr(); tick();
    chk("R6", "fail captured", status[2], 1);
    // pseudo-random phase
    lf = 16'hACE1;
    for (int i = 0; i < 3000; i++) begin
      lf = {lf[14:0], lf[15] ^ lf[13] ^ lf[12] ^ lf[10]};
      cmd_valid   = (lf[2:0] == 3'd0);
      cmd_is_meas = lf[3];
      cyc_start   = (lf[6:4] == 3'd1);
      cyc_stop    = (lf[8:5] == 4'd3);
      calc_done   = (lf[10:8] == 3'd2);
      alu_sat     = (lf[12:11] == 2'd1);
      mode_wr     = (lf[14:12] == 3'd5);
      mode_val    = lf[1:0];
      cfg_wr      = (lf[15:13] == 3'd6);
      cfg_val     = lf[7];
      mem_chk_valid = (lf[9:6] == 4'd9);
      mem_chk_fail  = lf[0];
      if (lf[15:9] == 7'd0) int_setup = lf[1:0];
      tick();
    end
    clr(); tick();
    summary();
  end
endmodule